// File: doc/BRIEF.md
# Prescaler-Tapped Watchdog Timer

This block guards a processor against runaway software. Once software starts it, the block must be cleared again and again; if a whole timeout passes without a clear, the block raises a reset request to the processor. It holds the request for a fixed number of cycles and then falls back to its idle state. The timeout is not kept in a wide counter. A 2-bit step counter advances on one-cycle tap pulses taken from one of two free-running prescaler chains, both modelled inside the block. The time-base chain counts every system clock, standing for the main oscillator. The watch chain counts once every `SUB_DIV` clocks, standing for a slow subclock.

A source bit and a 2-bit interval field pick the tap. Both are captured when the watchdog starts. While it runs they are frozen. The tap spacing `s` is 2^MAIN_TAPS[k] cycles for the time-base chain, or SUB_DIV·2^SUB_TAPS[k] cycles for the watch chain. The chains are never reset by a watchdog clear, so the first step after a clear can come anywhere from 1 to `s` cycles later. This gives an expiry window rather than a single point. A separate time-base clear input zeroes the time-base chain. When that chain is the source, this stretches the timeout. Systems that run the processor from the subclock should select the watch chain.

States: `WD_IDLE` (not started, no request) goes to `WD_RUN` on a start strobe. `WD_RUN` goes to `WD_FIRE` when a tap pulse arrives with the step counter at 3 and no clear in the same cycle. `WD_FIRE` drives the request and goes back to `WD_IDLE` after `RST_HOLD` cycles.

Top module: `wdt_top`

## Requirements
- R1: After reset `rst_req` is 0 and the block is in `WD_IDLE`.
- R2: While idle (never started, or after a request has ended), `rst_req` stays 0 for any length of time.
- R3: With `src_main`=1 captured, `rst_req` first goes high between 3s+1 and 4s cycles after the clock edge that took the start or the last clear, where s = 2^MAIN_TAPS[ivl_sel]. The step counter only increments by one or returns to 0.
- R4: With `src_main`=0 captured, the same window holds with s = SUB_DIV·2^SUB_TAPS[ivl_sel].
- R5: A `wd_clear` pulse while running zeroes the step counter and takes priority over a tap pulse in the same cycle. Clears spaced no more than 3s apart keep `rst_req` at 0 indefinitely.
- R6: `rst_req` stays high for exactly `RST_HOLD` consecutive cycles. After that the block is idle and issues no further request without a new start.
- R7: `src_main` and `ivl_sel` are captured at the start edge. Changes while running or firing have no effect on the timeout.
- R8: A `start` strobe while running is neither a clear nor a stop. Expiry still falls in the window measured from the first start.
- R9: With the time-base chain selected, `tb_clear` zeroes that chain. Pulses spaced closer than s suppress expiry. After the last such pulse with the step counter at 0, `rst_req` rises exactly 4s+1 cycles later.
- R10: With the watch chain selected, `tb_clear` has no effect on the timeout window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_main | input | 1 | Tap source: 1 = time-base chain, 0 = watch chain |
| ivl_sel | input | 2 | Tap index 0..3 selecting the interval |
| start | input | 1 | Start strobe, accepted only when idle |
| wd_clear | input | 1 | Watchdog clear strobe |
| tb_clear | input | 1 | Clears the time-base prescaler chain |
| rst_req | output | 1 | Reset request to the processor |

## Verification
The bench builds the block with time-base taps {2,3,4,5}, watch taps {1,2,3,4}, `SUB_DIV`=3 and `RST_HOLD`=4. With these values every tap spacing lies between 4 and 48 cycles. That makes it cheap to sweep every source and interval at several start phases, and to check each expiry against its computed window. Over long runs the short spacings also reach the exact 4s+1 stretch after a time-base clear, the clear-priority case, and idle silence.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_FIRE = 2'd2
    } wd_state_e;

    typedef struct packed {
        logic       src_main;
        logic [1:0] ivl;
    } wd_cfg_t;

    localparam int unsigned NUM_TAPS = 4;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned W    = 20,
    parameter int unsigned DIV  = 1,
    parameter int unsigned TAPS [wdt_pkg::NUM_TAPS] = '{12, 14, 16, 19}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    output logic [wdt_pkg::NUM_TAPS-1:0] tap_pulse
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;

    logic         tick;
    logic [W-1:0] chain_q;

    // Count enable: every cycle, or once per DIV cycles
    generate
        if (DIV <= 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            logic [DW-1:0] div_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == DW'(DIV - 1))
                    div_q <= '0;
                else
                    div_q <= div_q + DW'(1);
            end
            assign tick = (div_q == DW'(DIV - 1));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            chain_q <= '0;
        else if (clr)
            chain_q <= '0;
        else if (tick)
            chain_q <= chain_q + W'(1);
    end

    // One registered pulse per tap each time its low bits wrap
    generate
        for (genvar i = 0; i < wdt_pkg::NUM_TAPS; i++) begin : g_tap
            localparam logic [W-1:0] MASK = W'((64'd1 << TAPS[i]) - 64'd1);
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    tap_pulse[i] <= 1'b0;
                else
                    tap_pulse[i] <= !clr && tick && ((chain_q & MASK) == MASK);
            end
        end
    endgenerate

endmodule

// File: rtl/wdt_tap_mux.sv
module wdt_tap_mux (
    input  wdt_pkg::wd_cfg_t             cfg,
    input  logic [wdt_pkg::NUM_TAPS-1:0] main_taps,
    input  logic [wdt_pkg::NUM_TAPS-1:0] sub_taps,
    output logic                         tap
);
    always_comb begin
        if (cfg.src_main)
            tap = main_taps[cfg.ivl];
        else
            tap = sub_taps[cfg.ivl];
    end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
    parameter int unsigned RST_HOLD = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                wd_clear,
    input  logic                tap,
    input  wdt_pkg::wd_cfg_t    cfg_in,
    output wdt_pkg::wd_state_e  state,
    output logic [1:0]          step,
    output wdt_pkg::wd_cfg_t    cfg,
    output logic                rst_req
);
    import wdt_pkg::*;

    localparam int unsigned HW = $clog2(RST_HOLD + 1);

    wd_state_e     state_q, state_d;
    logic [1:0]    step_q;
    logic [HW-1:0] hold_q;
    wd_cfg_t       cfg_q;

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: if (start) state_d = WD_RUN;
            WD_RUN:  if (!wd_clear && tap && step_q == 2'd3) state_d = WD_FIRE;
            WD_FIRE: if (hold_q == HW'(RST_HOLD - 1)) state_d = WD_IDLE;
            default: state_d = WD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_IDLE;
        else
            state_q <= state_d;
    end

    // Step counter, hold timer and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= 2'd0;
            hold_q <= '0;
            cfg_q  <= '0;
        end else begin
            unique case (state_q)
                WD_IDLE: begin
                    step_q <= 2'd0;
                    hold_q <= '0;
                    if (start) cfg_q <= cfg_in;
                end
                WD_RUN: begin
                    hold_q <= '0;
                    if (wd_clear)
                        step_q <= 2'd0;
                    else if (tap)
                        step_q <= step_q + 2'd1;
                end
                WD_FIRE: begin
                    step_q <= 2'd0;
                    hold_q <= hold_q + HW'(1);
                end
                default: begin
                    step_q <= 2'd0;
                    hold_q <= '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        rst_req = (state_q == WD_FIRE);
        state   = state_q;
        step    = step_q;
        cfg     = cfg_q;
    end

endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int unsigned MAIN_W    = 20,
    parameter int unsigned SUB_W     = 16,
    parameter int unsigned SUB_DIV   = 122,
    parameter int unsigned MAIN_TAPS [wdt_pkg::NUM_TAPS] = '{12, 14, 16, 19},
    parameter int unsigned SUB_TAPS  [wdt_pkg::NUM_TAPS] = '{10, 13, 14, 15},
    parameter int unsigned RST_HOLD  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_main,
    input  logic [1:0] ivl_sel,
    input  logic       start,
    input  logic       wd_clear,
    input  logic       tb_clear,
    output logic       rst_req
);
    import wdt_pkg::*;

    logic [NUM_TAPS-1:0] main_taps_w, sub_taps_w;
    logic                tap_w;
    wd_cfg_t             cfg_in_w, cfg_w;
    wd_state_e           state_w;
    logic [1:0]          step_w;

    assign cfg_in_w = '{src_main: src_main, ivl: ivl_sel};

    wdt_prescaler #(.W(MAIN_W), .DIV(1), .TAPS(MAIN_TAPS)) u_tbase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tb_clear),
        .tap_pulse (main_taps_w)
    );

    wdt_prescaler #(.W(SUB_W), .DIV(SUB_DIV), .TAPS(SUB_TAPS)) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (1'b0),
        .tap_pulse (sub_taps_w)
    );

    wdt_tap_mux u_mux (
        .cfg       (cfg_w),
        .main_taps (main_taps_w),
        .sub_taps  (sub_taps_w),
        .tap       (tap_w)
    );

    wdt_ctrl #(.RST_HOLD(RST_HOLD)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wd_clear (wd_clear),
        .tap      (tap_w),
        .cfg_in   (cfg_in_w),
        .state    (state_w),
        .step     (step_w),
        .cfg      (cfg_w),
        .rst_req  (rst_req)
    );

endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int unsigned HOLD = 4
) (
    input logic               clk,
    input logic               rst_n,
    input wdt_pkg::wd_state_e state,
    input logic [1:0]         step,
    input wdt_pkg::wd_cfg_t   cfg,
    input logic               tap,
    input logic               start,
    input logic               wd_clear,
    input logic               rst_req
);
    import wdt_pkg::*;

    logic [15:0] high_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            high_run <= '0;
        else if (rst_req)
            high_run <= high_run + 16'd1;
        else
            high_run <= '0;
    end

    AST_STEP_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        step != $past(step) |-> (step == $past(step) + 2'd1) || (step == 2'd0)); // R3

    AST_EXPIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> ($past(state) == WD_RUN) && ($past(step) == 2'd3) && $past(tap)); // R3

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_RUN) && wd_clear |=> (step == 2'd0) && !rst_req); // R5

    AST_HOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> high_run < 16'(HOLD)); // R6

    AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req) |-> high_run == 16'(HOLD)); // R6

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WD_IDLE) && ($past(state) != WD_IDLE) |-> $stable(cfg)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_IDLE) && !start |=> !rst_req); // R2

endmodule

bind wdt_top wdt_checker #(.HOLD(RST_HOLD)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (state_w),
    .step     (step_w),
    .cfg      (cfg_w),
    .tap      (tap_w),
    .start    (start),
    .wd_clear (wd_clear),
    .rst_req  (rst_req)
);

// File: tb/sim_wdt_top.sv
`timescale 1ns/1ps
module sim_wdt_top;
    localparam int unsigned MT [4] = '{2, 3, 4, 5};
    localparam int unsigned ST [4] = '{1, 2, 3, 4};
    localparam int unsigned SDIV = 3;
    localparam int unsigned HOLD = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic src_main = 1'b1, start = 1'b0, wd_clear = 1'b0, tb_clear = 1'b0;
    logic [1:0] ivl_sel = 2'd0;
    logic rst_req;

    int vectors = 0, misses = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    wdt_top #(.MAIN_W(6), .SUB_W(5), .SUB_DIV(SDIV), .MAIN_TAPS(MT),
              .SUB_TAPS(ST), .RST_HOLD(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .src_main(src_main), .ivl_sel(ivl_sel),
        .start(start), .wd_clear(wd_clear), .tb_clear(tb_clear), .rst_req(rst_req)
    );

    function automatic int spacing(input bit sm, input int k);
        return sm ? (1 << MT[k]) : int'(SDIV) * (1 << ST[k]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            misses++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    // Drive a one-cycle strobe; returns after the edge that takes it
    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk) wd_clear = 1'b1;
        @(negedge clk) wd_clear = 1'b0;
    endtask

    // Cycles after the taking edge until rst_req is seen high
    task automatic wait_fire(input int limit, output int n);
        n = 0;
        while (n <= limit) begin
            @(negedge clk);
            n++;
            if (rst_req) break;
        end
    endtask

    task automatic quiet(input int cycles, output bit saw);
        saw = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (rst_req) saw = 1;
        end
    endtask

    task automatic hold_len(output int h);
        h = 1;
        while (h < 100) begin
            @(negedge clk);
            if (!rst_req) break;
            h++;
        end
    endtask

    initial begin
        int n, h, s;
        bit saw;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(rst_req == 1'b0, "R1 reset", rst_req, 0);
        rst_n = 1'b1;
        // R2: never started -> no request
        quiet(120, saw);
        check(!saw, "R2 idle quiet", saw, 0);

        // R3/R4/R6: sweep every source, interval and several start phases
        for (int sm = 1; sm >= 0; sm--) begin
            for (int k = 0; k < 4; k++) begin
                for (int ph = 0; ph < 3; ph++) begin
                    s = spacing(sm[0], k);
                    src_main = sm[0];
                    ivl_sel  = 2'(k);
                    repeat (ph * 5 + 1) @(negedge clk);
                    pulse_start();
                    wait_fire(4 * s + 4, n);
                    if (sm == 1)
                        check(n >= 3 * s + 1 && n <= 4 * s, "R3 window main", n, 4 * s);
                    else
                        check(n >= 3 * s + 1 && n <= 4 * s, "R4 window sub", n, 4 * s);
                    hold_len(h);
                    check(h == int'(HOLD), "R6 hold length", h, HOLD);
                end
            end
        end

        // R6: after the request, idle with no further request
        quiet(4 * spacing(0, 3) + 10, saw);
        check(!saw, "R6 idle after fire", saw, 0);

        // R7: config captured at start, later changes ignored
        src_main = 1'b1; ivl_sel = 2'd0;
        pulse_start();
        src_main = 1'b0; ivl_sel = 2'd3;
        wait_fire(200, n);
        s = spacing(1, 0);
        check(n >= 3 * s + 1 && n <= 4 * s, "R7 captured config", n, 4 * s);
        hold_len(h);

        // R5: periodic clears keep it quiet, then window from last clear
        src_main = 1'b1; ivl_sel = 2'd1;
        s = spacing(1, 1);
        pulse_start();
        saw = 0;
        for (int i = 0; i < 20; i++) begin
            bit q;
            quiet(2 * s - 2, q);
            if (q) saw = 1;
            pulse_clear();
        end
        check(!saw, "R5 clears suppress", saw, 0);
        wait_fire(4 * s + 4, n);
        check(n >= 3 * s + 1 && n <= 4 * s, "R5 window after clear", n, 4 * s);
        hold_len(h);

        // R8: repeated start while running is not a clear
        src_main = 1'b1; ivl_sel = 2'd2;
        s = spacing(1, 2);
        pulse_start();
        n = 0;
        while (n <= 4 * s + 4) begin
            @(negedge clk);
            n++;
            start = (n % 8 == 0);
            if (rst_req) break;
        end
        start = 1'b0;
        check(n >= 3 * s + 1 && n <= 4 * s, "R8 start ignored", n, 4 * s);
        hold_len(h);

        // R9: time-base clear suppresses, then exact stretch
        src_main = 1'b1; ivl_sel = 2'd1;
        s = spacing(1, 1);
        @(negedge clk) begin start = 1'b1; tb_clear = 1'b1; end
        @(negedge clk) begin start = 1'b0; tb_clear = 1'b0; end
        saw = 0;
        for (int i = 0; i < 20; i++) begin
            bit q;
            quiet(3, q);
            if (q) saw = 1;
            @(negedge clk) tb_clear = 1'b1;
            @(negedge clk) tb_clear = 1'b0;
        end
        check(!saw, "R9 tb_clear suppress", saw, 0);
        wait_fire(4 * s + 8, n);
        check(n == 4 * s + 1, "R9 stretch exact", n, 4 * s + 1);
        hold_len(h);

        // R10: tb_clear has no effect on the watch chain
        src_main = 1'b0; ivl_sel = 2'd0;
        s = spacing(0, 0);
        pulse_start();
        n = 0;
        while (n <= 4 * s + 4) begin
            @(negedge clk);
            n++;
            tb_clear = ~tb_clear;
            if (rst_req) break;
        end
        tb_clear = 1'b0;
        check(n >= 3 * s + 1 && n <= 4 * s, "R10 sub ignores tb_clear", n, 4 * s);
        hold_len(h);

        finish_run();
    end
endmodule